// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of an 8-bit successive-approximation converter in a small microcontroller. Software starts a conversion by writing the start bit. The block then stops sampling and steps a trial code through an external DAC and comparator, one bit per conversion clock, most significant bit first. It ends each conversion with a fixed frame of conversion clocks. At completion it stores the result, clears the start bit, raises a sticky done flag and returns to sampling. Before it accepts another start it waits a short recovery interval.

The conversion clock comes from the oscillator clock `clk`, divided by 2, 8 or 32. It can also come from an external tick input, which stands for a free-running RC source. In RC mode the block waits one instruction cycle (four oscillator clocks) before the conversion clock starts, so that a sleep instruction can run first. The CPU side is reduced to two write strobes, one for the control word and one for the flag.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, `go` and `adc_flag` are 0, `result` and `trial_code` are 0, `sample_en` is 1, and the clock select is 0.
- R2: Clock select value 0, 1 and 2 makes one conversion tick every 2, 8 and 32 `clk` cycles. Value 3 uses each `rc_tick` pulse as a tick. With a divider, the flag reads 1 exactly 11·N+1 falling edges after the start write.
- R3: A control write with the go bit set while idle sets `go`. In a divider mode, on the next clock `sample_en` drops to 0 and `trial_code` becomes 8'h80.
- R4: With clock select 3, `sample_en` stays 1 for four `clk` cycles after the start write. Then the conversion begins with `trial_code` at 8'h80.
- R5: On conversion ticks 1 to 8, the bit under test (bit 7 first, down to bit 0) keeps the value `cmp_in` has at that tick. The next lower bit is set at the same time.
- R6: A conversion lasts 11 ticks. On the 11th tick, `result` takes the resolved code, `go` clears, `adc_flag` sets, `trial_code` returns to 0 and `sample_en` returns to 1.
- R7: `result` keeps its previous value throughout a conversion. Only completion changes it.
- R8: After completion or abort, a new conversion cannot begin until two further ticks have passed. A start bit set during that interval stays pending and starts the conversion once the interval ends.
- R9: A control write with the go bit set while converting is ignored. The conversion keeps its timing.
- R10: A control write with the go bit clear during a conversion aborts it. `result` and `adc_flag` stay unchanged, `go` clears and sampling resumes.
- R11: `adc_flag` stays 1 until a flag write with data 0. A flag write loads `flag_wdata` unless completion sets the flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_go | input | 1 | Start bit value of the control write |
| ctl_clksel | input | 2 | Clock select of the control write: 0 /2, 1 /8, 2 /32, 3 external tick |
| flag_wr | input | 1 | Done-flag write strobe |
| flag_wdata | input | 1 | Value written to the done flag |
| rc_tick | input | 1 | External conversion tick, one `clk` wide |
| cmp_in | input | 1 | Comparator output: 1 when the input is at or above the trial code |
| go | output | 1 | Start bit, readable |
| sample_en | output | 1 | Sample-and-hold tracking enable |
| trial_code | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Conversion result register |
| adc_flag | output | 1 | Sticky conversion-done flag |

## Verification
The in-RTL properties check the following on every cycle: the tick counter stays inside the 11-tick frame, each resolved bit matches the comparator value at its tick, and the result never moves except on completion. They also check that completion and abort leave the flag, start bit and sampling in the required state, that no conversion starts straight out of the recovery interval, and that the flag stays set. Only the bench's scenarios can show end-to-end latency for each divider ratio, the four-cycle RC delay, the exact recovery delay before a pending start, and correct codes across analog levels. The bench compares the outputs against a behavioural model on every clock and also runs directed checks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RCWAIT = 2'd1,
    ST_CONV   = 2'd2,
    ST_HOLD   = 2'd3
  } seq_st_t;

  localparam logic [1:0] SEL_EXT = 2'd3;

  // Divider ratio chosen by a clock-select value.
  function automatic int unsigned pick_div(input logic [1:0] sel,
                                           input int unsigned da,
                                           input int unsigned db,
                                           input int unsigned dc);
    case (sel)
      2'd0:    return da;
      2'd1:    return db;
      default: return dc;
    endcase
  endfunction
endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_A = 2,
  parameter int unsigned DIV_B = 8,
  parameter int unsigned DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int DW = $clog2(DIV_C + 1);

  logic [DW-1:0] div_q;
  logic [DW-1:0] lim_m1;

  assign lim_m1 = DW'(pick_div(sel, DIV_A, DIV_B, DIV_C) - 1);
  assign tick   = run && ((sel == SEL_EXT) ? rc_tick : (div_q >= lim_m1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (restart || !run)   div_q <= '0;
    else if (tick)              div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  // R2: a stopped divider stays cleared
  p_div_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (div_q == '0));
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W = 8,
  localparam int IW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [IW-1:0]    bit_idx,
  input  logic             cmp_in,
  input  logic             commit,
  input  logic             clear,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  // Decide bit idx from the comparator and raise the next lower bit.
  function automatic logic [RES_W-1:0] resolve_step(input logic [RES_W-1:0] t,
                                                    input logic [IW-1:0] idx,
                                                    input logic c);
    logic [RES_W-1:0] r;
    r = t;
    for (int i = 0; i < RES_W; i++) begin
      if (i == int'(idx))     r[i] = c;
      if (i + 1 == int'(idx)) r[i] = 1'b1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      result <= '0;
    end else if (clear) begin
      trial  <= '0;
    end else if (load) begin
      trial  <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (commit) begin
      result <= trial;
      trial  <= '0;
    end else if (step) begin
      trial  <= resolve_step(trial, bit_idx, cmp_in);
    end
  end

  // R7: the result register moves only on completion
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(result));
  // R5: resolved bit equals the comparator value at its tick
  p_bit_decide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !load && !commit) |=> (trial[$past(bit_idx)] == $past(cmp_in)));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int FRAME_TAD = 11,
  parameter int HOLD_TAD  = 2,
  parameter int RC_WAIT   = 4,
  parameter int unsigned DIV_A = 2,
  parameter int unsigned DIV_B = 8,
  parameter int unsigned DIV_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_go,
  input  logic [1:0]       ctl_clksel,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic             go,
  output logic             sample_en,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] result,
  output logic             adc_flag
);
  localparam int TW = $clog2(FRAME_TAD + 1);
  localparam int HW = $clog2(HOLD_TAD + 1);
  localparam int WW = $clog2(RC_WAIT + 1);
  localparam int IW = $clog2(RES_W);

  seq_st_t       st;
  logic          go_q, flag_q;
  logic [1:0]    sel_q, sel_eff;
  logic [TW-1:0] tad_cnt;
  logic [HW-1:0] hcnt;
  logic [WW-1:0] wcnt;
  logic [IW-1:0] bit_idx;

  // Named internal events
  logic go_wr_val, busy, tick, abort_evt, start_evt, rc_ready;
  logic conv_enter, step_evt, done_evt, hold_end, tad_run, tad_restart;

  assign sel_eff     = ctl_wr ? ctl_clksel : sel_q;
  assign go_wr_val   = ctl_wr ? ctl_go : go_q;
  assign busy        = (st == ST_CONV) || (st == ST_RCWAIT);
  assign abort_evt   = busy && ctl_wr && !ctl_go;
  assign start_evt   = (st == ST_IDLE) && go_wr_val;
  assign rc_ready    = (st == ST_RCWAIT) && (wcnt == WW'(RC_WAIT - 1)) && !abort_evt;
  assign conv_enter  = (start_evt && (sel_eff != SEL_EXT)) || rc_ready;
  assign step_evt    = (st == ST_CONV) && tick && (tad_cnt < TW'(RES_W)) && !abort_evt;
  assign done_evt    = (st == ST_CONV) && tick && (tad_cnt == TW'(FRAME_TAD - 1)) && !abort_evt;
  assign hold_end    = (st == ST_HOLD) && tick && (hcnt == HW'(HOLD_TAD - 1));
  assign tad_run     = (st == ST_CONV) || (st == ST_HOLD);
  assign tad_restart = conv_enter || done_evt || abort_evt;
  assign bit_idx     = IW'(RES_W - 1) - IW'(tad_cnt);

  adc_tad_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tad (
    .clk(clk), .rst_n(rst_n), .run(tad_run), .restart(tad_restart),
    .sel(sel_q), .rc_tick(rc_tick), .tick(tick)
  );

  adc_sar_reg #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(conv_enter), .step(step_evt),
    .bit_idx(bit_idx), .cmp_in(cmp_in), .commit(done_evt), .clear(abort_evt),
    .trial(trial_code), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      go_q    <= 1'b0;
      flag_q  <= 1'b0;
      sel_q   <= 2'd0;
      tad_cnt <= '0;
      hcnt    <= '0;
      wcnt    <= '0;
    end else begin
      sel_q  <= sel_eff;
      go_q   <= done_evt ? 1'b0 : go_wr_val;
      flag_q <= done_evt ? 1'b1 : (flag_wr ? flag_wdata : flag_q);
      case (st)
        ST_IDLE: if (start_evt) begin
          if (sel_eff == SEL_EXT) begin st <= ST_RCWAIT; wcnt <= '0; end
          else begin st <= ST_CONV; tad_cnt <= '0; end
        end
        ST_RCWAIT: begin
          if (abort_evt)     begin st <= ST_HOLD; hcnt <= '0; end
          else if (rc_ready) begin st <= ST_CONV; tad_cnt <= '0; end
          else               wcnt <= wcnt + 1'b1;
        end
        ST_CONV: begin
          if (abort_evt || done_evt) begin st <= ST_HOLD; hcnt <= '0; end
          else if (tick)             tad_cnt <= tad_cnt + 1'b1;
        end
        default: begin
          if (hold_end)  st <= ST_IDLE;
          else if (tick) hcnt <= hcnt + 1'b1;
        end
      endcase
    end
  end

  assign go        = go_q;
  assign adc_flag  = flag_q;
  assign sample_en = (st != ST_CONV);

  // R6: the frame counter never passes the last tick
  p_frame_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tad_cnt < TW'(FRAME_TAD));
  // R6: completion clears go, sets the flag, resumes sampling
  p_done_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (adc_flag && !go && sample_en && (trial_code == '0)));
  // R3: sampling stops only with the MSB under test
  p_start_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) |-> (trial_code == {1'b1, {(RES_W-1){1'b0}}}));
  // R4: RC wait ends in a conversion with the MSB trial
  p_rc_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rc_ready |=> (!sample_en && (trial_code == {1'b1, {(RES_W-1){1'b0}}})));
  // R8: recovery never leads straight into a conversion
  p_hold_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |=> (st != ST_CONV));
  // R9: a repeated start during conversion keeps go set
  p_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_CONV) && ctl_wr && ctl_go && !done_evt) |=> go);
  // R10: abort keeps result and flag, resumes sampling
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !flag_wr) |=> (sample_en && !go && $stable(result) && $stable(adc_flag)));
  // R11: the flag holds until written to zero
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_flag && !(flag_wr && !flag_wdata)) |=> adc_flag);
endmodule

// File: tb/adc_sar_seq_bench.sv
module adc_sar_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, ctl_go = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [1:0] ctl_clksel = 2'd0;
  logic       rc_tick = 1'b0;
  logic       cmp_in;
  logic       go, sample_en, adc_flag;
  logic [7:0] trial_code, result;

  int tests = 0, fails = 0;
  logic [7:0] vin = 8'h00;
  int rc_cnt = 0;

  always #5 clk = ~clk;

  adc_sar_seq u_adc_sar_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_go(ctl_go),
    .ctl_clksel(ctl_clksel), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .rc_tick(rc_tick), .cmp_in(cmp_in), .go(go), .sample_en(sample_en),
    .trial_code(trial_code), .result(result), .adc_flag(adc_flag)
  );

  // Behavioural reference: 0 idle, 1 rc wait, 2 convert, 3 recovery
  int m_st = 0, m_div = 0, m_w = 0, m_tad = 0, m_h = 0, m_sel = 0;
  logic m_go = 1'b0, m_flag = 1'b0;
  logic [7:0] m_trial = 8'h00, m_res = 8'h00;

  // Analog model: comparator says input at or above the model's trial code
  assign cmp_in = (m_trial <= vin);

  always @(negedge clk) begin
    rc_cnt  = (rc_cnt == 4) ? 0 : rc_cnt + 1;
    rc_tick <= (rc_cnt == 4);
  end

  always @(posedge clk) begin : mdl
    int sel_now, n, bi;
    bit tk, ab, dn, go_now;
    logic [7:0] t;
    if (!rst_n) begin
      m_st <= 0; m_div <= 0; m_w <= 0; m_tad <= 0; m_h <= 0; m_sel <= 0;
      m_go <= 0; m_flag <= 0; m_trial <= 0; m_res <= 0;
    end else begin
      sel_now = ctl_wr ? int'(ctl_clksel) : m_sel;
      go_now  = ctl_wr ? ctl_go : m_go;
      n  = (m_sel == 0) ? 2 : (m_sel == 1) ? 8 : 32;
      tk = (m_st >= 2) && ((m_sel == 3) ? rc_tick : (m_div >= n - 1));
      ab = (m_st == 1 || m_st == 2) && ctl_wr && !ctl_go;
      dn = (m_st == 2) && !ab && tk && (m_tad == 10);
      m_sel  <= sel_now;
      m_go   <= dn ? 1'b0 : go_now;
      m_flag <= dn ? 1'b1 : (flag_wr ? flag_wdata : m_flag);
      case (m_st)
        0: begin
          m_div <= 0;
          if (go_now) begin
            if (sel_now == 3) begin m_st <= 1; m_w <= 0; end
            else begin m_st <= 2; m_tad <= 0; m_trial <= 8'h80; end
          end
        end
        1: begin
          m_div <= 0;
          if (ab) begin m_st <= 3; m_h <= 0; m_trial <= 0; end
          else if (m_w == 3) begin m_st <= 2; m_tad <= 0; m_trial <= 8'h80; end
          else m_w <= m_w + 1;
        end
        2: begin
          if (ab) begin m_st <= 3; m_h <= 0; m_div <= 0; m_trial <= 0; end
          else if (tk) begin
            m_div <= 0;
            if (m_tad < 8) begin
              bi = 7 - m_tad;
              t = m_trial; t[bi] = cmp_in;
              if (bi > 0) t[bi-1] = 1'b1;
              m_trial <= t;
            end
            if (m_tad == 10) begin m_res <= m_trial; m_trial <= 0; m_st <= 3; m_h <= 0; end
            else m_tad <= m_tad + 1;
          end else m_div <= m_div + 1;
        end
        default: begin
          if (tk) begin
            m_div <= 0;
            if (m_h == 1) m_st <= 0; else m_h <= m_h + 1;
          end else m_div <= m_div + 1;
        end
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    check("R6 go", int'(go), int'(m_go));
    check("R3 sample_en", int'(sample_en), int'(m_st != 2));
    check("R5 trial_code", int'(trial_code), int'(m_trial));
    check("R7 result", int'(result), int'(m_res));
    check("R11 adc_flag", int'(adc_flag), int'(m_flag));
  end

  task automatic clear_flag();
    @(negedge clk); flag_wr = 1; flag_wdata = 0;
    @(negedge clk); flag_wr = 0;
  endtask

  task automatic run_conv(input logic [1:0] sel, input logic [7:0] v, output int lat);
    @(negedge clk);
    vin = v; ctl_wr = 1; ctl_go = 1; ctl_clksel = sel;
    lat = 0;
    do begin
      @(negedge clk); ctl_wr = 0; lat++;
    end while (!adc_flag && lat < 3000);
  endtask

  initial begin
    int lat, cnt;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 go", int'(go), 0);
    check("R1 flag", int'(adc_flag), 0);
    check("R1 result", int'(result), 0);
    check("R1 trial", int'(trial_code), 0);
    check("R1 sample_en", int'(sample_en), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2/R6: divider latencies and codes
    run_conv(2'd0, 8'hA5, lat);
    check("R2 latency /2", lat, 11*2+1);
    check("R6 result A5", int'(result), 'hA5);
    clear_flag(); repeat (6) @(negedge clk);
    run_conv(2'd1, 8'h3C, lat);
    check("R2 latency /8", lat, 11*8+1);
    check("R6 result 3C", int'(result), 'h3C);
    clear_flag(); repeat (20) @(negedge clk);
    run_conv(2'd2, 8'hFF, lat);
    check("R2 latency /32", lat, 11*32+1);
    check("R6 result FF", int'(result), 'hFF);
    clear_flag(); repeat (70) @(negedge clk);

    // R7: old value visible mid-conversion
    @(negedge clk); vin = 8'h00; ctl_wr = 1; ctl_go = 1; ctl_clksel = 2'd0;
    @(negedge clk); ctl_wr = 0;
    repeat (8) @(negedge clk);
    check("R7 old result mid", int'(result), 'hFF);
    do @(negedge clk); while (!adc_flag);
    check("R6 result 00", int'(result), 0);

    // R11: sticky flag, cleared by a zero write
    repeat (10) @(negedge clk);
    check("R11 flag held", int'(adc_flag), 1);
    clear_flag();
    check("R11 flag cleared", int'(adc_flag), 0);
    repeat (6) @(negedge clk);

    // R8: start written right after completion waits two ticks
    run_conv(2'd1, 8'h5A, lat);
    ctl_wr = 1; ctl_go = 1; ctl_clksel = 2'd1; vin = 8'h81;
    cnt = 0;
    do begin @(negedge clk); ctl_wr = 0; cnt++; end while (sample_en && cnt < 200);
    check("R8 restart delay", cnt, 2*8+1);
    clear_flag();
    do @(negedge clk); while (!adc_flag);
    check("R8 pending result", int'(result), 'h81);
    clear_flag(); repeat (20) @(negedge clk);

    // R9: second start during conversion does not disturb timing
    @(negedge clk); vin = 8'h6E; ctl_wr = 1; ctl_go = 1; ctl_clksel = 2'd0;
    lat = 0;
    do begin
      @(negedge clk); lat++;
      ctl_wr = (lat == 6); ctl_go = 1;
    end while (!adc_flag && lat < 3000);
    check("R9 latency unchanged", lat, 11*2+1);
    check("R9 result", int'(result), 'h6E);
    clear_flag(); repeat (6) @(negedge clk);

    // R10: abort keeps result and flag
    keep = result;
    @(negedge clk); vin = 8'h11; ctl_wr = 1; ctl_go = 1; ctl_clksel = 2'd1;
    @(negedge clk); ctl_wr = 0;
    repeat (30) @(negedge clk);
    ctl_wr = 1; ctl_go = 0;
    @(negedge clk); ctl_wr = 0;
    check("R10 sampling resumed", int'(sample_en), 1);
    check("R10 go cleared", int'(go), 0);
    repeat (100) @(negedge clk);
    check("R10 result kept", int'(result), int'(keep));
    check("R10 flag kept", int'(adc_flag), 0);

    // R4: RC mode, four cycles of sampling before the conversion clock
    @(negedge clk); vin = 8'hC3; ctl_wr = 1; ctl_go = 1; ctl_clksel = 2'd3;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ctl_wr = 0;
      check("R4 still sampling", int'(sample_en), 1);
    end
    @(negedge clk);
    check("R4 conversion started", int'(sample_en), 0);
    check("R4 trial MSB", int'(trial_code), 'h80);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!adc_flag && cnt < 3000);
    check("R2 rc result", int'(result), 'hC3);
    repeat (20) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule